// File: doc/BRIEF.md
# Compressive-Sensing Measurement Encoder

This block sits behind the response outputs of a circuit under test. It turns each batch of `BATCH_N` response words into `MEAS_M` linear measurements, so only `MEAS_M` words leave the chip instead of `BATCH_N`. Each measurement row owns a Galois LFSR started from its own seed. Bit 0 of that LFSR is the row's 0/1 coefficient for the current response. The row adds the response to its running sum whenever that coefficient is 1. Off-chip software then rebuilds the deviations from the fault-free responses by sparse recovery.

When a batch completes, the sums move into a drain register and are shifted out one per cycle. The next batch accumulates while this happens. A bypass mode is used when recovery fails for a batch: the tester re-runs that batch with bypass set, and the raw responses are streamed out unchanged at full rate.

Top module: `cs_meas_encoder`

## Requirements
- R1: After reset, `meas_valid_o` and `meas_last_o` stay low until a batch has completed.
- R2: Measurement j equals the sum of every response whose coefficient for row j is 1. Row j's first coefficient is bit 0 of its seed (`seed_i[j*LFSR_W +: LFSR_W]`). After each accepted response the state becomes `(s >> 1) ^ (s[0] ? 16'hB400 : 0)` for the default `LFSR_W=16`, and the next coefficient is bit 0 of the new state.
- R3: Sums are `$clog2(BATCH_N)+RESP_W` bits wide (17 by default). An all-ones batch therefore produces an exact sum with no wrap.
- R4: Seeds are sampled only with the first response of a batch. A seed change later in the batch has no effect. Every batch that starts with the same seeds uses the same coefficient matrix.
- R5: Measurement 0 appears in the cycle after the clock edge that accepts the `BATCH_N`-th response. Measurements 1 to `MEAS_M-1` follow on consecutive cycles in index order, and `meas_last_o` is high only with measurement `MEAS_M-1`.
- R6: A cycle with `resp_valid_i` low is not part of the batch. Idle gaps inside a batch leave the measurements unchanged.
- R7: A batch may start in the cycle right after the previous batch ends. Both batches' measurements are then delivered correctly.
- R8: The mode is sampled with the first response of a batch. In bypass, each accepted response appears zero-extended on `meas_o` one cycle after acceptance, with `meas_last_o` on the `BATCH_N`-th response, and no measurements are emitted for that batch. A compressed batch must be followed by at least `MEAS_M` idle cycles before a bypass batch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| resp_i | input | RESP_W | Response word from the circuit under test |
| resp_valid_i | input | 1 | Response accepted on this edge |
| bypass_i | input | 1 | Raw-offload mode, sampled with the first response of a batch |
| seed_i | input | MEAS_M*LFSR_W | Per-row LFSR seeds, row j at bits j*LFSR_W upward |
| meas_o | output | $clog2(BATCH_N)+RESP_W | Measurement, or zero-extended raw response in bypass |
| meas_valid_o | output | 1 | `meas_o` holds a word |
| meas_last_o | output | 1 | Final word of the batch |

## Verification
Every result is due exactly one cycle after the edge that produces it. In compressed mode, measurement k is due k+1 cycles after the edge that accepts the final response. In bypass mode, each raw word is due one cycle after its own acceptance edge. A negedge monitor tags every output word with the cycle count. The bench checks those tags against the cycle in which it presented the final response (or each raw response), so a word that arrives one cycle early or late fails even when its value is right. Expected sums come from a separate LFSR model in the bench, fed the same responses and seeds.

// File: rtl/cs_enc_pkg.sv
package cs_enc_pkg;
  // Galois right-shift feedback masks for maximal-length sequences.
  function automatic logic [31:0] lfsr_taps(input int width);
    case (width)
      8:       return 32'h0000_00B8;
      32:      return 32'hA300_0000;
      default: return 32'h0000_B400;
    endcase
  endfunction
endpackage

// File: rtl/cs_batch_ctrl.sv
module cs_batch_ctrl #(
  parameter int BATCH_N = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic bypass_i,
  output logic first_o,
  output logic end_o,
  output logic byp_o
);
  localparam int CNT_W = $clog2(BATCH_N);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BATCH_N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;

  assign first_o = (cnt_q == '0);
  assign end_o   = take_i && (cnt_q == CNT_MAX);
  assign byp_o   = first_o ? bypass_i : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (take_i) begin
      cnt_q <= end_o ? '0 : cnt_q + 1'b1;
      if (first_o) mode_q <= bypass_i;
    end
  end

  p_batch_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> first_o);
  p_mode_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !first_o) |=> (mode_q == $past(mode_q)));
endmodule

// File: rtl/cs_meas_row.sv
module cs_meas_row #(
  parameter int RESP_W = 8,
  parameter int LFSR_W = 16,
  parameter int ACC_W  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              first_i,
  input  logic [RESP_W-1:0] resp_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [ACC_W-1:0]  sum_o
);
  localparam logic [LFSR_W-1:0] TAPS = LFSR_W'(cs_enc_pkg::lfsr_taps(LFSR_W));

  logic [LFSR_W-1:0] st_q, src, nxt;
  logic [ACC_W-1:0]  acc_q, base;

  // Seed and a zero base are taken directly on the first response of a batch.
  assign src   = first_i ? seed_i : st_q;
  assign nxt   = (src >> 1) ^ (src[0] ? TAPS : '0);
  assign base  = first_i ? '0 : acc_q;
  assign sum_o = base + (src[0] ? ACC_W'(resp_i) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      acc_q <= '0;
    end else if (take_i) begin
      st_q  <= nxt;
      acc_q <= sum_o;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (sum_o >= base));
  p_lfsr_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && src != '0) |=> (st_q != '0));
endmodule

// File: rtl/cs_drain.sv
module cs_drain #(
  parameter int MEAS_M = 16,
  parameter int RESP_W = 8,
  parameter int ACC_W  = 17
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [MEAS_M-1:0][ACC_W-1:0]  sums_i,
  input  logic                          raw_valid_i,
  input  logic                          raw_last_i,
  input  logic [RESP_W-1:0]             raw_i,
  output logic [ACC_W-1:0]              data_o,
  output logic                          valid_o,
  output logic                          last_o
);
  localparam int LW = $clog2(MEAS_M + 1);

  logic [MEAS_M-1:0][ACC_W-1:0] sh_q;
  logic [LW-1:0]                left_q;
  logic                         busy;
  logic                         rv_q, rl_q;
  logic [RESP_W-1:0]            rd_q;

  assign busy = (left_q != '0);

  for (genvar k = 0; k < MEAS_M; k++) begin : g_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sh_q[k] <= '0;
      else if (load_i) sh_q[k] <= sums_i[k];
      else if (busy) begin
        if (k == MEAS_M - 1) sh_q[k] <= '0;
        else                 sh_q[k] <= sh_q[(k + 1) % MEAS_M];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      rv_q   <= 1'b0;
      rl_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (load_i)    left_q <= LW'(MEAS_M);
      else if (busy) left_q <= left_q - 1'b1;
      rv_q <= raw_valid_i;
      rl_q <= raw_last_i;
      if (raw_valid_i) rd_q <= raw_i;
    end
  end

  assign data_o  = busy ? sh_q[0] : ACC_W'(rd_q);
  assign valid_o = busy || rv_q;
  assign last_o  = busy ? (left_q == LW'(1)) : (rv_q && rl_q);

  p_last_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  p_drain_contig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last_o && !load_i) |=> (valid_o && busy));
  p_no_collide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && rv_q));
endmodule

// File: rtl/cs_meas_encoder.sv
module cs_meas_encoder #(
  parameter int BATCH_N = 512,
  parameter int MEAS_M  = 16,
  parameter int RESP_W  = 8,
  parameter int LFSR_W  = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [RESP_W-1:0]                  resp_i,
  input  logic                               resp_valid_i,
  input  logic                               bypass_i,
  input  logic [MEAS_M*LFSR_W-1:0]           seed_i,
  output logic [$clog2(BATCH_N)+RESP_W-1:0]  meas_o,
  output logic                               meas_valid_o,
  output logic                               meas_last_o
);
  localparam int ACC_W = $clog2(BATCH_N) + RESP_W;

  logic                         first, bend, byp;
  logic [MEAS_M-1:0][ACC_W-1:0] sums;

  cs_batch_ctrl #(.BATCH_N(BATCH_N)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (resp_valid_i),
    .bypass_i (bypass_i),
    .first_o  (first),
    .end_o    (bend),
    .byp_o    (byp)
  );

  for (genvar j = 0; j < MEAS_M; j++) begin : g_row
    cs_meas_row #(.RESP_W(RESP_W), .LFSR_W(LFSR_W), .ACC_W(ACC_W)) u_row (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .take_i  (resp_valid_i),
      .first_i (first),
      .resp_i  (resp_i),
      .seed_i  (seed_i[j*LFSR_W +: LFSR_W]),
      .sum_o   (sums[j])
    );
  end

  cs_drain #(.MEAS_M(MEAS_M), .RESP_W(RESP_W), .ACC_W(ACC_W)) u_drain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (bend && !byp),
    .sums_i      (sums),
    .raw_valid_i (resp_valid_i && byp),
    .raw_last_i  (bend && byp),
    .raw_i       (resp_i),
    .data_o      (meas_o),
    .valid_o     (meas_valid_o),
    .last_o      (meas_last_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(meas_valid_o) |-> ($past(bend) || $past(resp_valid_i && byp)));
endmodule

// File: tb/sim_cs_meas_encoder.sv
module sim_cs_meas_encoder;
  localparam int N  = 512;
  localparam int M  = 16;
  localparam int RW = 8;
  localparam int LW = 16;
  localparam int AW = $clog2(N) + RW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [RW-1:0] resp_i = '0;
  logic          resp_valid_i = 1'b0;
  logic          bypass_i = 1'b0;
  logic [M*LW-1:0] seed_i;
  logic [AW-1:0] meas_o;
  logic          meas_valid_o, meas_last_o;

  cs_meas_encoder #(.BATCH_N(N), .MEAS_M(M), .RESP_W(RW), .LFSR_W(LW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .resp_i(resp_i), .resp_valid_i(resp_valid_i),
    .bypass_i(bypass_i), .seed_i(seed_i), .meas_o(meas_o),
    .meas_valid_o(meas_valid_o), .meas_last_o(meas_last_o));

  always #2 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  logic [M*LW-1:0] seeds_a, seeds_b;
  logic [RW-1:0]   stim [N];
  logic [AW-1:0]   expv [M];
  logic [AW-1:0]   cap_d [$];
  bit              cap_l [$];
  int              cap_c [$];
  int              t_last;
  int              lcg = 12345;

  always @(negedge clk_i)
    if (rst_ni && meas_valid_o) begin
      cap_d.push_back(meas_o);
      cap_l.push_back(meas_last_o);
      cap_c.push_back(cyc);
    end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] rnd();
    lcg = lcg * 1103515245 + 12345;
    return RW'(lcg >>> 16);
  endfunction

  // Independent model of the coefficient sequences (R2).
  task automatic model(input logic [M*LW-1:0] sd);
    for (int j = 0; j < M; j++) begin
      logic [LW-1:0] s;
      s = sd[j*LW +: LW];
      expv[j] = '0;
      for (int i = 0; i < N; i++) begin
        if (s[0]) expv[j] = expv[j] + AW'(stim[i]);
        s = (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0);
      end
    end
  endtask

  task automatic run_batch(input bit byp, input int gap, input bit swap, input bit tail);
    for (int i = 0; i < N; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) begin
        @(negedge clk_i);
        resp_valid_i = 1'b0;
      end
      @(negedge clk_i);
      resp_valid_i = 1'b1;
      resp_i = stim[i];
      if (i == 0) bypass_i = byp;
      if (i == 1) begin
        bypass_i = ~byp;
        if (swap) seed_i = seeds_b;
      end
      if (i == N - 1) t_last = cyc;
    end
    if (tail) begin
      @(negedge clk_i);
      resp_valid_i = 1'b0;
      bypass_i = 1'b0;
      seed_i = seeds_a;
    end
  endtask

  task automatic check_meas(input int base, input int t0, input string req);
    chk(cap_d.size() >= base + M, req, cap_d.size(), base + M);
    if (cap_d.size() < base + M) return;
    for (int j = 0; j < M; j++) begin
      chk(cap_d[base+j] == expv[j], req, cap_d[base+j], expv[j]);
      chk(cap_l[base+j] == (j == M - 1), {req, " last"}, cap_l[base+j], j == M - 1);
      chk(cap_c[base+j] == t0 + 1 + j, {req, " timing"}, cap_c[base+j], t0 + 1 + j);
    end
  endtask

  task automatic flush();
    repeat (M + 4) @(negedge clk_i);
  endtask

  task automatic t_reset();
    repeat (6) begin
      @(negedge clk_i);
      chk(meas_valid_o == 1'b0, "R1 valid", meas_valid_o, 0);
      chk(meas_last_o == 1'b0, "R1 last", meas_last_o, 0);
    end
  endtask

  task automatic t_basic();
    for (int i = 0; i < N; i++) stim[i] = rnd();
    model(seeds_a);
    cap_d.delete(); cap_l.delete(); cap_c.delete();
    run_batch(1'b0, 0, 1'b0, 1'b1);
    flush();
    chk(cap_d.size() == M, "R5 count", cap_d.size(), M);
    check_meas(0, t_last, "R2 R5 basic");
  endtask

  task automatic t_gaps();
    model(seeds_a);
    cap_d.delete(); cap_l.delete(); cap_c.delete();
    run_batch(1'b0, 7, 1'b0, 1'b1);
    flush();
    check_meas(0, t_last, "R6 gaps");
  endtask

  task automatic t_max();
    for (int i = 0; i < N; i++) stim[i] = '1;
    model(seeds_a);
    cap_d.delete(); cap_l.delete(); cap_c.delete();
    run_batch(1'b0, 0, 1'b0, 1'b1);
    flush();
    check_meas(0, t_last, "R3 all-ones");
  endtask

  task automatic t_seed_swap();
    for (int i = 0; i < N; i++) stim[i] = rnd();
    model(seeds_a);
    cap_d.delete(); cap_l.delete(); cap_c.delete();
    run_batch(1'b0, 0, 1'b1, 1'b1);
    flush();
    check_meas(0, t_last, "R4 seed swap");
  endtask

  task automatic t_b2b();
    int t1;
    logic [AW-1:0] e1 [M];
    for (int i = 0; i < N; i++) stim[i] = rnd();
    model(seeds_a);
    e1 = expv;
    cap_d.delete(); cap_l.delete(); cap_c.delete();
    run_batch(1'b0, 0, 1'b0, 1'b0);
    t1 = t_last;
    for (int i = 0; i < N; i++) stim[i] = RW'(i * 3);
    run_batch(1'b0, 0, 1'b0, 1'b1);
    flush();
    model(seeds_a);
    check_meas(M, t_last, "R7 second");
    expv = e1;
    check_meas(0, t1, "R7 first R4 reuse");
  endtask

  task automatic t_bypass();
    int tacc [N];
    for (int i = 0; i < N; i++) stim[i] = rnd();
    cap_d.delete(); cap_l.delete(); cap_c.delete();
    for (int i = 0; i < N; i++) begin
      @(negedge clk_i);
      resp_valid_i = 1'b1;
      resp_i = stim[i];
      bypass_i = (i == 0) ? 1'b1 : 1'b0;
      tacc[i] = cyc;
    end
    @(negedge clk_i);
    resp_valid_i = 1'b0;
    flush();
    chk(cap_d.size() == N, "R8 count", cap_d.size(), N);
    if (cap_d.size() == N)
      for (int i = 0; i < N; i++) begin
        chk(cap_d[i] == AW'(stim[i]), "R8 data", cap_d[i], stim[i]);
        chk(cap_l[i] == (i == N - 1), "R8 last", cap_l[i], i == N - 1);
        chk(cap_c[i] == tacc[i] + 1, "R8 timing", cap_c[i], tacc[i] + 1);
      end
  endtask

  task automatic t_after_bypass();
    for (int i = 0; i < N; i++) stim[i] = rnd();
    model(seeds_a);
    cap_d.delete(); cap_l.delete(); cap_c.delete();
    run_batch(1'b0, 0, 1'b0, 1'b1);
    flush();
    chk(cap_d.size() == M, "R8 return count", cap_d.size(), M);
    check_meas(0, t_last, "R8 return R2");
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < M; j++) begin
      seeds_a[j*LW +: LW] = 16'hACE1 ^ LW'(j * 16'h1357 + 1);
      seeds_b[j*LW +: LW] = 16'h5A5A + LW'(j * 16'h0101);
    end
    seed_i = seeds_a;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_gaps();
    t_max();
    t_seed_swap();
    t_b2b();
    t_bypass();
    t_after_bypass();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule